// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one accepted burst request into the byte address of every beat of that burst. A request carries a start address, an 8-bit length field, a 3-bit size field and a 2-bit burst type. Once the request is taken, the block presents the first beat address at once. It then steps to the next address on each cycle in which the consumer raises the beat-advance strobe. Alongside each address it gives the same address aligned down to the transfer size, and a flag that marks the final beat.

Requests are screened before they start. A request is refused if its size exceeds the bus width, if it uses the reserved burst code, if it is a wrapping burst with a beat count outside 2, 4, 8 and 16, or if it is an incrementing burst whose bytes would spill into the next 4 KB page. A refused request never starts, and the block reports it with a one-cycle error pulse. The block is meant to be the address path of a memory-mapped subordinate or a DMA engine.

Top module: `axb_addr_gen`

## Requirements
- R1: Burst type 2'b00 is FIXED: every beat of the burst presents the start address unchanged.
- R2: Burst type 2'b01 is INCR: the first beat presents the start address, and each later beat presents the previous address aligned down to the size plus the bytes per beat.
- R3: Burst type 2'b10 is WRAP: the window is (length+1) times bytes per beat, with its lower edge at the current address aligned down to the window size; a step that reaches the window's upper edge returns to its lower edge, and any other step is INCR-like.
- R4: A legal burst has length+1 beats; `beat_last` is high exactly on the beat whose index equals the length field, and advancing on that beat drops `busy` on the next cycle.
- R5: Bytes per beat are 2 to the power of `req_size`; a size above BUS_LOG2 is illegal.
- R6: A WRAP request whose length field is not 1, 3, 7 or 15 is illegal.
- R7: An INCR request is illegal when start + (length+1)*bytes − 1 falls in a different 4 KB page than the start address, including a wrap past the top of the address space.
- R8: Burst type 2'b11 is reserved and illegal.
- R9: An illegal request sampled while idle does not start a burst: `busy` stays low, and `req_err` is high for exactly the one cycle after the request.
- R10: `beat_aligned` always equals `beat_addr` with its low `size` bits cleared.
- R11: While busy, a cycle without `beat_advance` holds `beat_addr`, `beat_aligned` and `beat_last`, and `req_valid` has no effect.
- R12: After reset, `busy`, `beat_last` and `req_err` are low, and `beat_addr` and `beat_aligned` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken only while idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | Burst type: 00 FIXED, 01 INCR, 10 WRAP, 11 reserved |
| beat_adv | input | 1 | Consumer has used the current beat |
| busy | output | 1 | A burst is in progress |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_aligned | output | ADDR_W | Current address aligned down to the size |
| beat_last | output | 1 | Current beat is the final one |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench builds the block with a 20-bit address and a 16-byte bus (BUS_LOG2 = 4). The short address makes random start addresses land near page ends and near the top of the address space often, which exercises the 4 KB check and its overflow case. The narrow bus leaves sizes 5 to 7 as legal-looking field values that must be refused, while size 4 still allows wrap windows of up to 256 bytes.

// File: rtl/axb_pkg.sv
package axb_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;
endpackage

// File: rtl/axb_legal.sv
module axb_legal
  import axb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_LOG2  = 3,
  parameter int PAGE_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [7:0]        len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic              ok
);
  localparam int SW = ADDR_W + 1;

  logic [SW-1:0] total;
  logic [SW-1:0] end_b;
  logic          size_ok;
  logic          wrap_ok;
  logic          page_ok;

  always_comb begin
    total   = ({{(SW-8){1'b0}}, len} + SW'(1)) << size;
    end_b   = {1'b0, start} + total - SW'(1);
    size_ok = (size <= 3'(BUS_LOG2));
    wrap_ok = (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    page_ok = (end_b[SW-1:PAGE_LOG2] == {1'b0, start[ADDR_W-1:PAGE_LOG2]});
    unique case (burst_e'(burst))
      BT_FIXED: ok = size_ok;
      BT_INCR:  ok = size_ok && page_ok;
      BT_WRAP:  ok = size_ok && wrap_ok;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/axb_step.sv
module axb_step
  import axb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [7:0]        len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] cur_aligned,
  output logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] nxt_aligned
);
  logic [ADDR_W-1:0] lane_mask;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] win_low;

  always_comb begin
    lane_mask   = (ADDR_W'(1) << size) - ADDR_W'(1);
    cur_aligned = cur & ~lane_mask;
    inc         = cur_aligned + lane_mask + ADDR_W'(1);
    win_mask    = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
    win_low     = cur & ~win_mask;
    unique case (burst_e'(burst))
      BT_INCR: nxt = inc;
      BT_WRAP: nxt = ((inc & win_mask) == '0) ? win_low : inc;
      default: nxt = cur;
    endcase
    nxt_aligned = nxt & ~lane_mask;
  end
endmodule

// File: rtl/axb_addr_gen.sv
module axb_addr_gen
  import axb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_LOG2  = 3,
  parameter int PAGE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  input  logic              beat_adv,
  output logic              busy,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] beat_aligned,
  output logic              beat_last,
  output logic              req_err
);
  logic              busy_q, last_q, err_q;
  logic [ADDR_W-1:0] addr_q, algn_q;
  logic [7:0]        idx_q, len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;

  logic              req_ok;
  logic [ADDR_W-1:0] st_addr;
  logic [7:0]        st_len;
  logic [2:0]        st_size;
  logic [1:0]        st_burst;
  logic [ADDR_W-1:0] cur_algn, nxt, nxt_algn;

  axb_legal #(.ADDR_W(ADDR_W), .BUS_LOG2(BUS_LOG2), .PAGE_LOG2(PAGE_LOG2)) u_legal (
    .start(req_addr), .len(req_len), .size(req_size), .burst(req_burst), .ok(req_ok)
  );

  assign st_addr  = busy_q ? addr_q  : req_addr;
  assign st_len   = busy_q ? len_q   : req_len;
  assign st_size  = busy_q ? size_q  : req_size;
  assign st_burst = busy_q ? burst_q : req_burst;

  axb_step #(.ADDR_W(ADDR_W)) u_step (
    .cur(st_addr), .len(st_len), .size(st_size), .burst(st_burst),
    .cur_aligned(cur_algn), .nxt(nxt), .nxt_aligned(nxt_algn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      algn_q  <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          if (req_ok) begin
            busy_q  <= 1'b1;
            addr_q  <= req_addr;
            algn_q  <= cur_algn;
            idx_q   <= '0;
            last_q  <= (req_len == 8'd0);
            len_q   <= req_len;
            size_q  <= req_size;
            burst_q <= req_burst;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (beat_adv) begin
        if (last_q) begin
          busy_q <= 1'b0;
          last_q <= 1'b0;
        end else begin
          addr_q <= nxt;
          algn_q <= nxt_algn;
          idx_q  <= idx_q + 8'd1;
          last_q <= ((idx_q + 8'd1) == len_q);
        end
      end
    end
  end

  assign busy         = busy_q;
  assign beat_addr    = addr_q;
  assign beat_aligned = algn_q;
  assign beat_last    = last_q;
  assign req_err      = err_q;

  // R4: the final-beat flag only appears inside a burst
  a_r4_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    last_q |-> busy_q);

  // R4: advancing the final beat ends the burst
  a_r4_last_idle: assert property (@(posedge clk) disable iff (rst)
    busy_q && last_q && beat_adv |=> !busy_q);

  // R9: a refused request leaves the block idle
  a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !busy_q);

  // R9: the error is a single-cycle pulse
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

  // R11: a stalled beat holds its outputs
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    busy_q && !beat_adv |=> $stable(addr_q) && $stable(algn_q) && $stable(last_q));

  // R1: a FIXED burst never moves its address
  a_r1_fixed: assert property (@(posedge clk) disable iff (rst)
    busy_q && (burst_q == 2'b00) |=> $stable(addr_q));
endmodule

// File: tb/sim_axb_addr_gen.sv
module sim_axb_addr_gen;
  localparam int AW = 20;
  localparam int BL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_len = '0;
  logic [2:0]    req_size = '0;
  logic [1:0]    req_burst = '0;
  logic          beat_adv = 1'b0;
  logic          busy, beat_last, req_err;
  logic [AW-1:0] beat_addr, beat_aligned;

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;

  always #4 clk = ~clk;

  axb_addr_gen #(.ADDR_W(AW), .BUS_LOG2(BL), .PAGE_LOG2(12)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
    .beat_adv(beat_adv), .busy(busy), .beat_addr(beat_addr),
    .beat_aligned(beat_aligned), .beat_last(beat_last), .req_err(req_err)
  );

  task automatic chk(string rq, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic string bad_tag(longint a, int l, int s, int b);
    longint e;
    if (s > BL) return "R5";
    if (b == 3) return "R8";
    if (b == 2 && !(l == 1 || l == 3 || l == 7 || l == 15)) return "R6";
    if (b == 1) begin
      e = a + (longint'(l + 1) << s) - 1;
      if ((a >> 12) != (e >> 12)) return "R7";
    end
    return "";
  endfunction

  function automatic longint exp_next(longint a, int l, int s, int b);
    longint by, al, lo, wl;
    by = longint'(1) << s;
    al = (a / by) * by;
    if (b == 0) return a;
    if (b == 1) return (al + by) % (longint'(1) << AW);
    wl = longint'(l + 1) * by;
    lo = (a / wl) * wl;
    if (al + by - lo >= wl) return lo;
    return al + by;
  endfunction

  task automatic run_burst(longint a, int l, int s, int b);
    string  t, rb;
    longint ea;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_len = 8'(l);
    req_size = 3'(s); req_burst = 2'(b); beat_adv = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    t = bad_tag(a, l, s, b);
    if (t != "") begin
      chk({t, "/R9 err"}, req_err, 1);
      chk({t, "/R9 busy"}, busy, 0);
      @(negedge clk);
      chk("R9 pulse", req_err, 0);
      chk("R9 idle", busy, 0);
      return;
    end
    rb = (b == 0) ? "R1" : (b == 1) ? "R2" : "R3";
    chk("R9 no err", req_err, 0);
    chk("R4 busy", busy, 1);
    ea = a;
    for (int i = 0; i <= l; i++) begin
      chk({rb, " addr"}, beat_addr, ea);
      chk("R10 aligned", beat_aligned, (ea >> s) << s);
      chk("R4 last", beat_last, (i == l));
      forever begin
        beat_adv  = ($urandom % 3) != 0;
        req_valid = $urandom % 2;
        req_addr  = AW'($urandom);
        req_burst = 2'($urandom);
        req_len   = 8'($urandom);
        @(negedge clk);
        if (beat_adv) break;
        chk("R11 hold addr", beat_addr, ea);
        chk("R11 hold last", beat_last, (i == l));
      end
      beat_adv = 1'b0;
      req_valid = 1'b0;
      ea = exp_next(ea, l, s, b);
    end
    chk("R4 idle", busy, 0);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12 busy", busy, 0);
    chk("R12 last", beat_last, 0);
    chk("R12 err", req_err, 0);
    chk("R12 addr", beat_addr, 0);
    chk("R12 aligned", beat_aligned, 0);
    // directed corners
    run_burst('h00100, 3, 2, 0);   // R1 fixed
    run_burst('h00103, 4, 2, 1);   // R2 unaligned incr
    run_burst('h00038, 3, 2, 2);   // R3 wrap 38,3C,30,34
    run_burst('h020F0, 15, 4, 2);  // R3 wrap 256-byte window
    run_burst('h00FF0, 1, 4, 1);   // R7 crosses page
    run_burst('h00FF0, 0, 4, 1);   // R7 ends exactly at page end, legal
    run_burst('hFFFF8, 1, 3, 1);   // R7 overflows address space
    run_burst('h00000, 255, 0, 1); // R4 full 256-beat incr
    run_burst('h00040, 0, 5, 1);   // R5 size above bus
    run_burst('h00040, 2, 2, 2);   // R6 wrap length 3 beats
    run_burst('h00040, 1, 2, 3);   // R8 reserved
    run_burst('h00044, 0, 2, 2);   // R6 wrap single beat
    for (int n = 0; n < 400; n++) begin
      longint a;
      int l, s, b;
      b = $urandom % 4;
      if (b == 3 && ($urandom % 3) != 0) b = $urandom % 3;
      s = (($urandom % 8) == 0) ? ($urandom % 8) : ($urandom % (BL + 1));
      if (b == 2 && ($urandom % 5) != 0) l = (2 << ($urandom % 4)) - 1;
      else l = (($urandom % 16) == 0) ? ($urandom % 256) : ($urandom % 24);
      a = $urandom % (1 << AW);
      if (($urandom % 4) == 0) a = (a | 'hFC0) & ((1 << AW) - 1);
      run_burst(a, l, s, b);
    end
    finish_up();
  end
endmodule